// File: doc/BRIEF.md
# Sticky Lock Configuration Register for a Timer and Watchdog Block

This unit holds one byte of configuration for a timer and watchdog block and sits between the register bus and that block's registers. The byte selects the watchdog clock source and the watchdog service method. It also carries one lock bit for each guarded register, including one for the configuration byte itself. Each usable bit can only be set. Once a bit holds 1, only reset clears it, so a runaway program cannot undo the protection.

Every bus access is screened in the same cycle it is presented. A write strobe reaches the addressed register only when its lock bit is clear and the current power mode allows the access. A read returns the register's data only under the same conditions; otherwise the read bus shows 8'h00. Outside active mode only the service-match register can be reached.

Top module: `tw_cfg_guard`

## Requirements
- R1: After reset every configuration bit is 0, both select outputs are 0, and reading address 0 in active mode returns 8'h00.
- R2: Configuration bit 4 drives `wd_clk_sel_o` and bit 5 drives `svc_match_mode_o`. Bits 0 to 3 are the lock bits for, in order: the configuration byte (address 0), the prescaler (address 1), the timer reload and timer control registers (addresses 2 and 3), and the watchdog count (address 4).
- R3: Writing 0 to a configuration bit that holds 1 leaves it at 1. Only `rst_ni` clears it.
- R4: Bits 7:6 of the configuration byte always read 0, and writing 1 to them has no effect.
- R5: While bit 0 is set, writes to address 0 produce no strobe and leave the configuration unchanged, and reads of address 0 return 8'h00.
- R6: While a register's lock bit is set, a write to that register produces no strobe and a read of it returns 8'h00.
- R7: The service-match register (address 5) has no lock bit and can always be reached in every mode.
- R8: When `mode_i` is not 2'b00 (active), every register except address 5 is blocked: it gets no write strobe, reads as 8'h00, and a write to address 0 leaves the configuration unchanged.
- R9: A permitted write raises exactly the addressed bit of `reg_we_o` in the same cycle as `bus_wr_i`. A permitted read of addresses 1 to 5 returns the matching 8-bit slot of `reg_rdata_i`, with address 1 in bits 7:0.
- R10: Addresses 6 and 7 raise no strobe and read as 8'h00.
- R11: A permitted write to address 0 takes effect at the next clock edge. Every bit set by that write applies, including functional bits written together with the self-lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Power mode: 00 active, 01 power save, 10 idle, 11 halt |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write request for the addressed register |
| bus_wdata_i | input | 8 | Write data |
| reg_rdata_i | input | 40 | Read data of registers at addresses 1 to 5, 8 bits each, address 1 lowest |
| bus_rdata_o | output | 8 | Screened read data |
| reg_we_o | output | 6 | Screened write strobes, one per address 0 to 5 |
| wd_clk_sel_o | output | 1 | Watchdog clock source select (configuration bit 4) |
| svc_match_mode_o | output | 1 | Watchdog service-by-match select (configuration bit 5) |

## Verification
Two functions can land in the same cycle: a write that sets a lock bit, and the gating that the new lock bit controls. The bench sends one write to address 0 that sets the self-lock bit and the clock select together. It expects the clock select to apply, and it expects the very next write to address 0 to be dropped. Power-mode gating and locking also meet. The bench writes address 0 while outside active mode, then returns to active mode and judges by reading back the unchanged byte.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 3;
  localparam int unsigned NREG  = 6;
  localparam int unsigned NLOCK = 4;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_SAVE   = 2'b01,
    MODE_IDLE   = 2'b10,
    MODE_HALT   = 2'b11
  } pmode_e;

  localparam int unsigned A_CFG = 0;
  localparam int unsigned A_PRE = 1;
  localparam int unsigned A_RLD = 2;
  localparam int unsigned A_TCS = 3;
  localparam int unsigned A_WDC = 4;
  localparam int unsigned A_SVC = 5;

  localparam int unsigned B_LCFG   = 0;
  localparam int unsigned B_LPRE   = 1;
  localparam int unsigned B_LTMR   = 2;
  localparam int unsigned B_LWDC   = 3;
  localparam int unsigned B_CLKSEL = 4;
  localparam int unsigned B_SVCSEL = 5;

  localparam logic [DW-1:0] CFG_WMASK = 8'h3F;

  // lock bit guarding each address, -1 when unguarded
  function automatic int lock_bit(int unsigned a);
    case (a)
      A_CFG:        return int'(B_LCFG);
      A_PRE:        return int'(B_LPRE);
      A_RLD, A_TCS: return int'(B_LTMR);
      A_WDC:        return int'(B_LWDC);
      default:      return -1;
    endcase
  endfunction
endpackage

// File: rtl/tw_cfg_reg.sv
module tw_cfg_reg
  import tw_cfg_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter logic [W-1:0] WMASK = CFG_WMASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  // set-only: bits accumulate until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_q | (wdata_i & WMASK);
  end

  assign cfg_o = cfg_q;

  AST_SET_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cfg_q) & ~cfg_q) == '0)); // R3

  AST_SELF_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q[B_LCFG]) |-> $stable(cfg_q)); // R5

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_q & ~WMASK) == '0)); // R4
endmodule

// File: rtl/tw_acc_gate.sv
module tw_acc_gate
  import tw_cfg_pkg::*;
#(
  parameter int unsigned N  = NREG,
  parameter int unsigned A  = AW,
  parameter int unsigned NL = NLOCK
) (
  input  logic [1:0]    mode_i,
  input  logic [A-1:0]  addr_i,
  input  logic          wr_i,
  input  logic [NL-1:0] lock_i,
  output logic [N-1:0]  we_o,
  output logic          rd_ok_o
);
  logic          active;
  logic [N-1:0]  permit;

  assign active = (mode_i == MODE_ACTIVE);

  for (genvar k = 0; k < N; k++) begin : g_reg
    localparam int LB = lock_bit(k);
    logic locked;
    logic mode_ok;
    if (LB >= 0) begin : g_lk
      assign locked = lock_i[LB];
    end else begin : g_nolk
      assign locked = 1'b0;
    end
    if (k == A_SVC) begin : g_any_mode
      assign mode_ok = 1'b1;
    end else begin : g_act_only
      assign mode_ok = active;
    end
    assign permit[k] = (addr_i == A'(k)) && mode_ok && !locked;
  end

  assign we_o    = permit & {N{wr_i}};
  assign rd_ok_o = |permit;
endmodule

// File: rtl/tw_rd_mux.sv
module tw_rd_mux
  import tw_cfg_pkg::*;
#(
  parameter int unsigned N = NREG,
  parameter int unsigned A = AW,
  parameter int unsigned W = DW
) (
  input  logic             rd_ok_i,
  input  logic [A-1:0]     addr_i,
  input  logic [W-1:0]     cfg_i,
  input  logic [(N-1)*W-1:0] slots_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] slot [N];

  assign slot[0] = cfg_i;
  for (genvar k = 1; k < N; k++) begin : g_slot
    assign slot[k] = slots_i[(k-1)*W +: W];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_ok_i) begin
      for (int k = 0; k < N; k++) begin
        if (addr_i == A'(k)) rdata_o = slot[k];
      end
    end
  end
endmodule

// File: rtl/tw_cfg_guard.sv
module tw_cfg_guard
  import tw_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADDR_W = AW,
  parameter int unsigned N_REG  = NREG,
  localparam int unsigned SLOT_W = (N_REG - 1) * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [SLOT_W-1:0] reg_rdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [N_REG-1:0]  reg_we_o,
  output logic              wd_clk_sel_o,
  output logic              svc_match_mode_o
);
  logic [DATA_W-1:0] cfg;
  logic              rd_ok;

  tw_acc_gate #(.N(N_REG), .A(ADDR_W), .NL(NLOCK)) i_gate (
    .mode_i  (mode_i),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .lock_i  (cfg[NLOCK-1:0]),
    .we_o    (reg_we_o),
    .rd_ok_o (rd_ok)
  );

  tw_cfg_reg #(.W(DATA_W), .WMASK(CFG_WMASK)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_o[A_CFG]),
    .wdata_i (bus_wdata_i),
    .cfg_o   (cfg)
  );

  tw_rd_mux #(.N(N_REG), .A(ADDR_W), .W(DATA_W)) i_rd (
    .rd_ok_i (rd_ok),
    .addr_i  (bus_addr_i),
    .cfg_i   (cfg),
    .slots_i (reg_rdata_i),
    .rdata_o (bus_rdata_o)
  );

  assign wd_clk_sel_o     = cfg[B_CLKSEL];
  assign svc_match_mode_o = cfg[B_SVCSEL];

  AST_LOCK_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg[B_LPRE] |-> !reg_we_o[A_PRE]); // R6
  AST_LOCK_TMR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg[B_LTMR] |-> !(reg_we_o[A_RLD] || reg_we_o[A_TCS])); // R6
  AST_LOCK_WDC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg[B_LWDC] |-> !reg_we_o[A_WDC]); // R6
  AST_LOCK_CFG_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg[B_LCFG] && bus_addr_i == ADDR_W'(A_CFG)) |-> (bus_rdata_o == '0)); // R5
  AST_MODE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_ACTIVE) |-> ((reg_we_o & ~(N_REG'(1) << A_SVC)) == '0)); // R8
  AST_WE_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o != '0) |-> (bus_wr_i && $onehot0(reg_we_o))); // R9
  AST_BAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i >= ADDR_W'(N_REG)) |-> (reg_we_o == '0 && bus_rdata_o == '0)); // R10
endmodule

// File: tb/test_tw_cfg_guard.sv
module test_tw_cfg_guard;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [5:0] we;
    logic [7:0] rd;
    logic       clk;
    logic       svc;
    string      tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [2:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [39:0] reg_rdata_i;
  logic [7:0]  bus_rdata_o;
  logic [5:0]  reg_we_o;
  logic        wd_clk_sel_o;
  logic        svc_match_mode_o;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  for (genvar j = 0; j < 5; j++) begin : g_rd
    assign reg_rdata_i[j*8 +: 8] = 8'hA1 + 8'(j);
  end

  tw_cfg_guard i_tw_cfg_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .reg_rdata_i(reg_rdata_i), .bus_rdata_o(bus_rdata_o), .reg_we_o(reg_we_o),
    .wd_clk_sel_o(wd_clk_sel_o), .svc_match_mode_o(svc_match_mode_o)
  );

  // monitor: compares outputs mid-cycle against the queued expectation
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (reg_we_o !== e.we || bus_rdata_o !== e.rd ||
          wd_clk_sel_o !== e.clk || svc_match_mode_o !== e.svc) begin
        n_fail++;
        $display("FAIL %s: we=%b/%b rd=%h/%h clk=%b/%b svc=%b/%b (actual/expected)",
                 e.tag, reg_we_o, e.we, bus_rdata_o, e.rd,
                 wd_clk_sel_o, e.clk, svc_match_mode_o, e.svc);
      end
    end
  end

  task automatic xact(input logic [1:0] md, input logic wr, input logic [2:0] a,
                      input logic [7:0] d, input logic [5:0] xwe, input logic [7:0] xrd,
                      input logic xclk, input logic xsvc, input string tag);
    exp_t e;
    @(posedge clk_i);
    #1;
    mode_i = md; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = d;
    e.we = xwe; e.rd = xrd; e.clk = xclk; e.svc = xsvc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_bus();
    @(posedge clk_i);
    #1;
    bus_wr_i = 1'b0; mode_i = 2'b00; bus_addr_i = 3'd7;
    @(posedge clk_i);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    xact(2'b00, 0, 3'd0, 8'h00, 6'b000000, 8'h00, 0, 0, "R1");
    // R9 unlocked read/write pass-through
    xact(2'b00, 0, 3'd1, 8'h00, 6'b000000, 8'hA1, 0, 0, "R9");
    xact(2'b00, 1, 3'd1, 8'h55, 6'b000010, 8'hA1, 0, 0, "R9");
    // R2/R4 functional bits set, reserved dropped
    xact(2'b00, 1, 3'd0, 8'hF0, 6'b000001, 8'h00, 0, 0, "R2");
    xact(2'b00, 0, 3'd0, 8'h00, 6'b000000, 8'h30, 1, 1, "R4");
    // R3 zero write does not clear
    xact(2'b00, 1, 3'd0, 8'h00, 6'b000001, 8'h30, 1, 1, "R3");
    xact(2'b00, 0, 3'd0, 8'h00, 6'b000000, 8'h30, 1, 1, "R3");
    // R6 prescaler lock
    xact(2'b00, 1, 3'd0, 8'h02, 6'b000001, 8'h30, 1, 1, "R6");
    xact(2'b00, 1, 3'd1, 8'hFF, 6'b000000, 8'h00, 1, 1, "R6");
    xact(2'b00, 1, 3'd2, 8'h11, 6'b000100, 8'hA2, 1, 1, "R6");
    // R6 timer lock covers addresses 2 and 3
    xact(2'b00, 1, 3'd0, 8'h04, 6'b000001, 8'h32, 1, 1, "R6");
    xact(2'b00, 1, 3'd2, 8'h00, 6'b000000, 8'h00, 1, 1, "R6");
    xact(2'b00, 0, 3'd3, 8'h00, 6'b000000, 8'h00, 1, 1, "R6");
    // R6 watchdog count lock; R7 match register still open
    xact(2'b00, 1, 3'd0, 8'h08, 6'b000001, 8'h36, 1, 1, "R6");
    xact(2'b00, 1, 3'd4, 8'h00, 6'b000000, 8'h00, 1, 1, "R6");
    xact(2'b00, 1, 3'd5, 8'h5C, 6'b100000, 8'hA5, 1, 1, "R7");
    // R8 non-active modes
    xact(2'b01, 1, 3'd5, 8'h5C, 6'b100000, 8'hA5, 1, 1, "R8");
    xact(2'b10, 0, 3'd5, 8'h00, 6'b000000, 8'hA5, 1, 1, "R8");
    xact(2'b01, 1, 3'd0, 8'h01, 6'b000000, 8'h00, 1, 1, "R8");
    xact(2'b10, 0, 3'd1, 8'h00, 6'b000000, 8'h00, 1, 1, "R8");
    xact(2'b11, 0, 3'd0, 8'h00, 6'b000000, 8'h00, 1, 1, "R8");
    xact(2'b00, 0, 3'd0, 8'h00, 6'b000000, 8'h3E, 1, 1, "R8");
    // R10 unused addresses
    xact(2'b00, 1, 3'd6, 8'hFF, 6'b000000, 8'h00, 1, 1, "R10");
    xact(2'b00, 0, 3'd7, 8'h00, 6'b000000, 8'h00, 1, 1, "R10");
    idle_bus();
    // second phase from a fresh reset
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    xact(2'b00, 0, 3'd0, 8'h00, 6'b000000, 8'h00, 0, 0, "R1");
    // R11 self-lock plus clock select in one write
    xact(2'b00, 1, 3'd0, 8'h11, 6'b000001, 8'h00, 0, 0, "R11");
    xact(2'b00, 0, 3'd0, 8'h00, 6'b000000, 8'h00, 1, 0, "R5");
    xact(2'b00, 1, 3'd0, 8'h20, 6'b000000, 8'h00, 1, 0, "R5");
    xact(2'b00, 0, 3'd1, 8'h00, 6'b000000, 8'hA1, 1, 0, "R5");
    xact(2'b00, 1, 3'd1, 8'h00, 6'b000010, 8'hA1, 1, 0, "R11");
    idle_bus();
    @(posedge clk_i);
    done = 1'b1;
    report();
  end
endmodule